// File: doc/BRIEF.md
# Serial Memory Read Engine

This block is the slave-side read path of a byte-wide serial nonvolatile memory. The host lowers chip select and clocks in an 8-bit instruction on the serial data input. For a read, two address bytes follow. The block then streams bytes from its internal array on the serial data output for as long as chip select stays low. After each byte the address advances by one. Past the top of the array it wraps to zero, so a single command can sweep the whole array again and again.

The serial clock, chip select and data input are oversampled by a faster system clock. They pass through synchronizers, and the serial clock feeds an edge detector. Input bits are taken on rising serial-clock edges. Output bits change on falling edges, as in SPI mode 0.

The array is a small register memory of `2**ADDR_BITS` bytes. It is filled through a separate parallel load port. Address bits above the array size are discarded. A command is refused when the write-busy flag is raised, and raising chip select ends a transfer at any bit.

Top module: `spiReadEngine`

## Requirements
- R1: The instruction is taken first, 8 bits, most significant bit first, on rising serial-clock edges. Code 0x03 selects a read and is followed by a 16-bit address, most significant bit first. The first data bit is driven after the falling edge that follows the 24th rising edge.
- R2: Data bytes leave most significant bit first. `miso` changes only after falling serial-clock edges and is stable when a rising edge is seen.
- R3: `misoOe` stays low through the instruction and address phases. It is high only while data is being shifted out.
- R4: While chip select stays low, each further byte comes from the next higher address.
- R5: After address `2**ADDR_BITS-1`, the next byte comes from address 0.
- R6: A rising edge on `csN` at any bit ends the transfer, and `misoOe` is low no more than 3 system clocks later. The next falling edge of `csN` starts a fresh instruction.
- R7: The start address may be any byte, with no alignment rule.
- R8: If `wip` is high when the 8th instruction bit is taken, the command is refused and `misoOe` stays low until `csN` rises.
- R9: Address bits at positions `ADDR_BITS` and above are ignored.
- R10: Any instruction code other than 0x03 is ignored for the rest of the transaction, and no output is driven.
- R11: `wpN` has no effect on reads.
- R12: When `loadEn` is high on a system clock edge, `loadData` is written to the array at `loadAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| wpN | input | 1 | Active-low write protect; no effect on reads |
| wip | input | 1 | Write cycle in progress; refuses new reads |
| miso | output | 1 | Serial data to the host |
| misoOe | output | 1 | Output enable for `miso`; the pad is high-impedance when low |
| loadEn | input | 1 | Array load strobe |
| loadAddr | input | ADDR_BITS | Array load address |
| loadData | input | 8 | Array load data |

## Verification
The bench covers four boundary cases:
- A start address near the top, and a 260-byte stream across the whole array. A design that does not wrap would return bytes from outside the array, or stop. A design that skips or repeats an address would shift every later byte.
- An address with junk in its upper bits. If those bits leaked into the address, the wrong byte would come back.
- A busy flag, a foreign instruction code and an asserted write protect. A refused command must never enable the output, while write protect must not block a read.
- A chip select raised in the middle of a byte. A design that kept its old bit position would misframe the next read, and one that kept the enable would leave the pad driven.

// File: rtl/spiRdPkg.sv
package spiRdPkg;

  localparam int CMD_BITS = 8;
  localparam int ADDR_FIELD_BITS = 16;
  localparam int PHASE_CNT_W = $clog2(ADDR_FIELD_BITS);
  localparam logic [7:0] OP_READ = 8'h03;

  typedef enum logic [1:0] {
    ST_CMD,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } rdState_t;

  // strobes from control to datapath, one system clock wide
  typedef struct packed {
    logic shiftIn;
    logic loadAddr;
    logic fetchByte;
    logic shiftOut;
  } rdStrobes_t;

endpackage

// File: rtl/spiRdSync.sv
module spiRdSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic csNIn,
  input  logic mosiIn,
  output logic sclkRise,
  output logic sclkFall,
  output logic csNS,
  output logic mosiS
);

  logic [STAGES-1:0] sclkPipe;
  logic [STAGES-1:0] csPipe;
  logic [STAGES-1:0] mosiPipe;
  logic sclkLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      mosiPipe <= '0;
      sclkLast <= 1'b0;
    end else begin
      sclkPipe <= {sclkPipe[STAGES-2:0], sclkIn};
      csPipe   <= {csPipe[STAGES-2:0], csNIn};
      mosiPipe <= {mosiPipe[STAGES-2:0], mosiIn};
      sclkLast <= sclkPipe[STAGES-1];
    end
  end

  assign sclkRise = sclkPipe[STAGES-1] & ~sclkLast;
  assign sclkFall = ~sclkPipe[STAGES-1] & sclkLast;
  assign csNS     = csPipe[STAGES-1];
  assign mosiS    = mosiPipe[STAGES-1];

endmodule

// File: rtl/spiRdCtrl.sv
module spiRdCtrl
  import spiRdPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csNS,
  input  logic       sclkRise,
  input  logic       sclkFall,
  input  logic       wip,
  input  logic [7:0] opNow,
  output rdStrobes_t stb,
  output logic       outEnable,
  output logic       cmdDone,
  output rdState_t   curState
);

  localparam logic [PHASE_CNT_W-1:0] CMD_LAST  = PHASE_CNT_W'(CMD_BITS - 1);
  localparam logic [PHASE_CNT_W-1:0] ADDR_LAST = PHASE_CNT_W'(ADDR_FIELD_BITS - 1);

  logic [PHASE_CNT_W-1:0] bitCnt;
  logic [2:0] outIdx;
  logic addrDone;

  always_comb begin
    stb      = '0;
    cmdDone  = 1'b0;
    addrDone = 1'b0;
    if (!csNS) begin
      case (curState)
        ST_CMD: if (sclkRise) begin
          stb.shiftIn = 1'b1;
          cmdDone     = (bitCnt == CMD_LAST);
        end
        ST_ADDR: if (sclkRise) begin
          stb.shiftIn  = 1'b1;
          addrDone     = (bitCnt == ADDR_LAST);
          stb.loadAddr = addrDone;
        end
        ST_DATA: if (sclkFall) begin
          stb.fetchByte = (outIdx == 3'd0);
          stb.shiftOut  = (outIdx != 3'd0);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState  <= ST_CMD;
      bitCnt    <= '0;
      outIdx    <= '0;
      outEnable <= 1'b0;
    end else if (csNS) begin
      curState  <= ST_CMD;
      bitCnt    <= '0;
      outIdx    <= '0;
      outEnable <= 1'b0;
    end else begin
      case (curState)
        ST_CMD: if (sclkRise) begin
          if (cmdDone) begin
            bitCnt   <= '0;
            curState <= (opNow == OP_READ && !wip) ? ST_ADDR : ST_SKIP;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_ADDR: if (sclkRise) begin
          if (addrDone) begin
            bitCnt   <= '0;
            curState <= ST_DATA;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_DATA: if (sclkFall) begin
          outIdx    <= outIdx + 1'b1;
          outEnable <= 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/spiRdDatapath.sv
module spiRdDatapath
  import spiRdPkg::*;
#(
  parameter int ADDR_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 mosiS,
  input  rdStrobes_t           stb,
  input  logic                 loadEn,
  input  logic [ADDR_BITS-1:0] loadAddr,
  input  logic [7:0]           loadData,
  output logic [7:0]           opNow,
  output logic [ADDR_BITS-1:0] addrNow,
  output logic                 misoBit
);

  localparam int DEPTH   = 1 << ADDR_BITS;
  localparam int SHIFT_W = (ADDR_BITS - 1 > CMD_BITS - 1) ? ADDR_BITS - 1 : CMD_BITS - 1;

  logic [SHIFT_W-1:0] inShift;
  logic [7:0] outShift;
  logic [7:0] memArr [DEPTH];
  logic [ADDR_BITS-1:0] capAddr;

  assign opNow   = {inShift[CMD_BITS-2:0], mosiS};
  assign capAddr = {inShift[ADDR_BITS-2:0], mosiS};  // upper address bits fall off here
  assign misoBit = outShift[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift  <= '0;
      outShift <= '0;
      addrNow  <= '0;
    end else begin
      if (stb.shiftIn) inShift <= {inShift[SHIFT_W-2:0], mosiS};
      if (stb.loadAddr) begin
        addrNow <= capAddr;
      end else if (stb.fetchByte) begin
        addrNow <= addrNow + 1'b1;  // natural wrap at the array top
      end
      if (stb.fetchByte) begin
        outShift <= memArr[addrNow];
      end else if (stb.shiftOut) begin
        outShift <= {outShift[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (loadEn) memArr[loadAddr] <= loadData;
  end

endmodule

// File: rtl/spiReadEngine.sv
module spiReadEngine
  import spiRdPkg::*;
#(
  parameter int ADDR_BITS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclk,
  input  logic                 csN,
  input  logic                 mosi,
  input  logic                 wpN,
  input  logic                 wip,
  output logic                 miso,
  output logic                 misoOe,
  input  logic                 loadEn,
  input  logic [ADDR_BITS-1:0] loadAddr,
  input  logic [7:0]           loadData
);

  logic sclkRise, sclkFall, csNS, mosiS;
  logic cmdDone, outEnable;
  logic [7:0] opNow;
  logic [ADDR_BITS-1:0] addrNow;
  rdStrobes_t ctlStb;
  rdState_t curState;

  spiRdSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .csNIn(csN), .mosiIn(mosi),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .csNS(csNS), .mosiS(mosiS)
  );

  spiRdCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .csNS(csNS), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .wip(wip), .opNow(opNow), .stb(ctlStb), .outEnable(outEnable),
    .cmdDone(cmdDone), .curState(curState)
  );

  spiRdDatapath #(.ADDR_BITS(ADDR_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .mosiS(mosiS), .stb(ctlStb),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .opNow(opNow), .addrNow(addrNow), .misoBit(miso)
  );

  assign misoOe = outEnable;

endmodule

// File: rtl/spiReadEngineChk.sv
module spiReadEngineChk
  import spiRdPkg::*;
#(
  parameter int ADDR_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 csN,
  input logic                 wpN,
  input logic                 wip,
  input logic                 miso,
  input logic                 misoOe,
  input logic                 sclkRise,
  input logic                 cmdDone,
  input logic [7:0]           opNow,
  input logic [ADDR_BITS-1:0] addrNow,
  input rdStrobes_t           ctlStb,
  input rdState_t             curState
);

  AST_HIZ_AFTER_CS: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !misoOe); // R6

  AST_OE_ONLY_DATA: assert property (@(posedge clk) disable iff (!rstN)
    misoOe |-> (curState == ST_DATA)); // R3

  AST_MISO_HOLD_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (sclkRise && misoOe) |-> $stable(miso)); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctlStb.fetchByte |=> (addrNow == ADDR_BITS'($past(addrNow) + 1'b1))); // R4

  AST_REJECT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdDone && wip) |=> (curState == ST_SKIP)); // R8

  AST_FOREIGN_OP: assert property (@(posedge clk) disable iff (!rstN)
    (cmdDone && opNow != OP_READ) |=> (curState == ST_SKIP)); // R10

  AST_WP_NO_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (cmdDone && !wip && !wpN && opNow == OP_READ) |=> (curState == ST_ADDR)); // R11

endmodule

bind spiReadEngine spiReadEngineChk #(.ADDR_BITS(ADDR_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .wpN(wpN), .wip(wip), .miso(miso),
  .misoOe(misoOe), .sclkRise(sclkRise), .cmdDone(cmdDone), .opNow(opNow),
  .addrNow(addrNow), .ctlStb(ctlStb), .curState(curState)
);

// File: tb/spiReadEngine_bench.sv
module spiReadEngine_bench;

  localparam int ADDR_BITS = 8;
  localparam int DEPTH = 1 << ADDR_BITS;
  localparam int HALF = 6;
  localparam int NV = 8;

  // stimulus table: opcode, address, bytes, wip, wpN
  localparam logic [7:0]  V_OP   [NV] = '{8'h03, 8'h03, 8'h03, 8'h03, 8'h03, 8'h03, 8'h0B, 8'h03};
  localparam logic [15:0] V_ADDR [NV] = '{16'h0000, 16'h0037, 16'h00FE, 16'hA512,
                                          16'h0040, 16'h0010, 16'h0010, 16'h0010};
  localparam int          V_N    [NV] = '{3, 2, 4, 2, 2, 2, 2, 260};
  localparam logic        V_WIP  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic        V_WP   [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

  logic clk = 1'b0;
  logic rstN, sclk, csN, mosi, wpN, wip, loadEn;
  logic miso, misoOe;
  logic [ADDR_BITS-1:0] loadAddr;
  logic [7:0] loadData;
  logic [7:0] model [DEPTH];
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  spiReadEngine #(.ADDR_BITS(ADDR_BITS)) u_spiReadEngine (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .wpN(wpN),
    .wip(wip), .miso(miso), .misoOe(misoOe), .loadEn(loadEn),
    .loadAddr(loadAddr), .loadData(loadData)
  );

  function automatic string tagOf(int v);
    case (v)
      0: return "R1/R2";
      1: return "R7";
      2: return "R5";
      3: return "R9";
      4: return "R11";
      5: return "R8";
      6: return "R10";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, output logic seen, output logic seenOe);
    mosi = b;
    waitNeg(HALF);
    seen = miso;
    seenOe = misoOe;
    sclk = 1'b1;
    waitNeg(HALF);
    sclk = 1'b0;
  endtask

  task automatic sendHeader(input logic [7:0] op, input logic [15:0] addr);
    logic s, o;
    int oeSeen = 0;
    for (int i = 7; i >= 0; i--) begin sendBit(op[i], s, o); oeSeen += o; end
    for (int i = 15; i >= 0; i--) begin sendBit(addr[i], s, o); oeSeen += o; end
    check(oeSeen == 0, "R3 header output enable", oeSeen, 0);
  endtask

  task automatic runRead(input logic [7:0] op, input logic [15:0] addr, input int n,
                         input logic wipV, input logic wpV, input string tag);
    logic s, o;
    logic [7:0] b;
    bit expectData;
    int oeBad;
    expectData = (op == 8'h03) && !wipV;
    wip = wipV;
    wpN = wpV;
    csN = 1'b0;
    waitNeg(HALF);
    sendHeader(op, addr);
    for (int k = 0; k < n; k++) begin
      oeBad = 0;
      b = '0;
      for (int j = 0; j < 8; j++) begin
        sendBit(1'b0, s, o);
        b = {b[6:0], s};
        if (o != expectData) oeBad++;
      end
      check(oeBad == 0, {tag, " output enable in data"}, oeBad, 0);
      if (expectData)
        check(b == model[(int'(addr) + k) % DEPTH], tag, b, model[(int'(addr) + k) % DEPTH]);
    end
    csN = 1'b1;
    wip = 1'b0;
    wpN = 1'b1;
    waitNeg(4);
    check(misoOe == 1'b0, "R6 release after read", misoOe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic s, o;
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; mosi = 1'b0; wpN = 1'b1; wip = 1'b0;
    loadEn = 1'b0; loadAddr = '0; loadData = '0;
    waitNeg(5);
    check(misoOe == 1'b0, "R3 reset output enable", misoOe, 0);
    rstN = 1'b1;
    waitNeg(2);
    check(misoOe == 1'b0, "R3 after reset", misoOe, 0);

    // preload through the parallel port (R12)
    for (int i = 0; i < DEPTH; i++) begin
      loadEn = 1'b1;
      loadAddr = ADDR_BITS'(i);
      loadData = 8'((i * 37 + 11) ^ (i >> 2));
      model[i] = loadData;
      waitNeg(1);
    end
    loadEn = 1'b0;
    waitNeg(2);

    for (int v = 0; v < NV; v++)
      runRead(V_OP[v], V_ADDR[v], V_N[v], V_WIP[v], V_WP[v], tagOf(v));

    // R12: overwrite one byte and read across it
    loadEn = 1'b1; loadAddr = 8'h20; loadData = 8'h5A; model[32] = 8'h5A;
    waitNeg(1);
    loadEn = 1'b0;
    waitNeg(2);
    runRead(8'h03, 16'h001F, 3, 1'b0, 1'b1, "R12");

    // R6: abort in the middle of the first data byte
    csN = 1'b0;
    waitNeg(HALF);
    sendHeader(8'h03, 16'h0030);
    for (int j = 0; j < 3; j++) sendBit(1'b0, s, o);
    check(misoOe == 1'b1, "R1 output active before abort", misoOe, 1);
    csN = 1'b1;
    waitNeg(4);
    check(misoOe == 1'b0, "R6 abort releases output", misoOe, 0);
    waitNeg(4);
    runRead(8'h03, 16'h0031, 2, 1'b0, 1'b1, "R6 fresh read");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule